// File: doc/BRIEF.md
# Multiplexed DRAM Device Responder

This block behaves like a 16-bit fast page dynamic memory seen from its pins, built to sit opposite a memory controller or a refresh scheduler in simulation and in synthesizable test fixtures. It samples the active-low row strobe, the two byte-lane column strobes, write enable, output enable, the shared address bus and the input data on every rising edge of a fast clock. Each strobe edge is found by comparing the pin with its value at the previous edge. The array is small and set by parameters. Row and column address bits above the configured widths are dropped.

The block sorts every memory cycle into one of seven classes. A cycle is an early write when write enable is already low as the column strobe falls. It is a delayed write when write enable falls later and no read data has been shown. It is a read-modify-write when write enable falls later and read data has already been shown. The other classes are read, row-only refresh, column-before-row refresh and standby. A column strobe held low through a row-strobe cycle gives a hidden refresh, and the read data stays on the pins. A column strobe fall after a column-before-row refresh, with the row strobe still low, opens the refreshed row for access.

An age counter for each row tracks the time since that row was last refreshed. If a row is accessed after it has gone stale, a sticky error flag is set.

Top module: `dram_resp`

## Requirements
- R1: After reset, `dq_drv` is 00, `refresh_err` is 0 and `cyc_class` is 0 (standby). Whenever the row strobe and both column strobes are sampled high, `cyc_class` reads 0 one cycle later.
- R2: A row-strobe fall with both column strobes high latches the row from `addr[ROW_BITS-1:0]`. A later column-strobe fall with write enable high reads the word at column `addr[COL_BITS-1:0]`, and `cyc_class` becomes 1 (read). Higher address bits have no effect.
- R3: If write enable is low when a lane's column strobe falls, that lane's byte of `dq_in` is written (early write). `cyc_class` becomes 2, and the lane is never driven during that cycle.
- R4: Lane 0 is `dq_out[7:0]` under `lcas_n` and lane 1 is `dq_out[15:8]` under `ucas_n`. A lane drives (its `dq_drv` bit is 1) one cycle after it is sampled with its column strobe low, output enable low and read data held. Otherwise the bit is 0 and the lane outputs zero.
- R5: A write-enable fall while a lane's column strobe is low after a read, with no data driven yet in that cycle, writes that lane's byte of `dq_in` at the latched column. `cyc_class` becomes 3 (delayed write).
- R6: The same write-enable fall after the lane has already driven its read data also writes, but `cyc_class` becomes 4 (read-modify-write).
- R7: A row-strobe fall with both column strobes high sets `cyc_class` to 5 (row-only refresh), refreshes the addressed row and drives nothing.
- R8: A row-strobe fall while any column strobe is low sets `cyc_class` to 6. It refreshes the row held in the internal refresh counter, which starts at 0 after reset and then increments, wrapping at 2^ROW_BITS. Outputs stay undriven unless read data is held from before.
- R9: In a hidden refresh, a read lane whose column strobe and output enable stay low keeps driving the same data while the row strobe rises and falls again.
- R10: After a column-before-row refresh, a column-strobe high-then-low sequence with the row strobe still low accesses the row that refresh used, at column `addr[COL_BITS-1:0]`.
- R11: `refresh_err` is set, and held until reset, when a column strobe falls in a row cycle whose row was at least `REFRESH_WIN` clock cycles old when the row strobe fell. Age counts from reset or from the row's last refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Column strobe for lane 0, active low |
| ucas_n | input | 1 | Column strobe for lane 1, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | 2*LANE_W | Write data from the controller |
| dq_out | output | 2*LANE_W | Read data, zero on undriven lanes |
| dq_drv | output | 2 | Per-lane drive enable (1 = driven, 0 = high impedance) |
| cyc_class | output | 3 | Current cycle class, encodings as in R1 to R8 |
| refresh_err | output | 1 | Sticky stale-row access flag |

## Verification
A wrong row or column latch, or a refresh counter that steps wrongly, shows up as wrong data on the next read of the affected word. In the counter-test path it shows one access after the refresh. A wrong cycle class or a wrong drive gate shows on `cyc_class` and `dq_drv` one cycle after the strobe edge that caused it. A corrupted write stays hidden until the same location is read again, which the random mix of writes and reads reaches within a few operations. A bad age counter shows as a missed or false `refresh_err` at the first column access after an idle stretch.

// File: rtl/dram_resp_pkg.sv
`timescale 1ns/1ps
package dram_resp_pkg;

    typedef enum logic [2:0] {
        CYC_STANDBY    = 3'd0,
        CYC_READ       = 3'd1,
        CYC_EARLY_WR   = 3'd2,
        CYC_DELAYED_WR = 3'd3,
        CYC_RMW        = 3'd4,
        CYC_ROW_REF    = 3'd5,
        CYC_CBR        = 3'd6
    } cyc_class_e;

endpackage

// File: rtl/dram_resp_array.sv
`timescale 1ns/1ps
module dram_resp_array #(
    parameter int ROW_BITS = 5,
    parameter int COL_BITS = 3,
    parameter int LANE_W   = 8,
    parameter int LANES    = 2
) (
    input  logic                         clk,
    input  logic [LANES-1:0]             wr_en,
    input  logic [ROW_BITS+COL_BITS-1:0] wr_addr,
    input  logic [LANES*LANE_W-1:0]      wr_data,
    input  logic [ROW_BITS+COL_BITS-1:0] rd_addr,
    output logic [LANES*LANE_W-1:0]      rd_data
);
    localparam int DEPTH = 1 << (ROW_BITS + COL_BITS);

    // one byte-wide store per lane so that each column strobe writes alone
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en[g]) begin
                store[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = store[rd_addr];
    end

endmodule

// File: rtl/dram_resp_ages.sv
`timescale 1ns/1ps
module dram_resp_ages #(
    parameter int ROW_BITS    = 5,
    parameter int REFRESH_WIN = 100000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ref_en,
    input  logic [ROW_BITS-1:0] sel_row,
    output logic                sel_stale
);
    localparam int ROWS  = 1 << ROW_BITS;
    localparam int AGE_W = $clog2(REFRESH_WIN + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(REFRESH_WIN);

    logic [ROWS-1:0] stale_vec;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [AGE_W-1:0] age_d, age_q;
        logic             hit;

        assign hit = ref_en && (sel_row == ROW_BITS'(r));

        always_comb begin
            age_d = age_q;
            if (hit) begin
                age_d = '0;
            end else if (age_q != AGE_MAX) begin
                age_d = age_q + 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) age_q <= '0;
            else     age_q <= age_d;
        end

        assign stale_vec[r] = (age_q == AGE_MAX);

        // R11: a row refreshed at this edge is not reported stale afterwards
        a_r11_fresh_after_refresh: assert property (@(posedge clk) disable iff (rst)
            hit |=> !stale_vec[r]);
    end

    assign sel_stale = stale_vec[sel_row];

endmodule

// File: rtl/dram_resp.sv
`timescale 1ns/1ps
module dram_resp
    import dram_resp_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int ROW_BITS    = 5,
    parameter int COL_BITS    = 3,
    parameter int LANE_W      = 8,
    parameter int REFRESH_WIN = 100000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ras_n,
    input  logic                  lcas_n,
    input  logic                  ucas_n,
    input  logic                  we_n,
    input  logic                  oe_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [2*LANE_W-1:0]   dq_in,
    output logic [2*LANE_W-1:0]   dq_out,
    output logic [1:0]            dq_drv,
    output logic [2:0]            cyc_class,
    output logic                  refresh_err
);
    localparam int LANES  = 2;
    localparam int DATA_W = LANES * LANE_W;
    localparam int WADDR  = ROW_BITS + COL_BITS;

    typedef struct packed {
        logic                ras;
        logic [LANES-1:0]    cas;
        logic                we;
        logic [ROW_BITS-1:0] row;
        logic [COL_BITS-1:0] col;
        logic                stale;
        logic [ROW_BITS-1:0] ctr;
        logic [LANES-1:0]    act;
        logic [LANES-1:0]    early;
        logic [LANES-1:0]    valid;
        logic [LANES-1:0]    shown;
        logic [LANES-1:0]    drv;
        logic [DATA_W-1:0]   dout;
        cyc_class_e          cls;
        logic                err;
    } st_t;

    st_t st_d, st_q;

    logic [LANES-1:0]    cas_n;
    logic                ras_fall, ras_rise, we_fall;
    logic [LANES-1:0]    cas_fall, cas_rise, wlanes;
    logic [ROW_BITS-1:0] row_sel;
    logic                row_stale;
    logic [LANES-1:0]    wr_en;
    logic [COL_BITS-1:0] wr_col;
    logic [DATA_W-1:0]   rd_data;
    logic                unused_addr_hi;

    assign unused_addr_hi = ^addr[ADDR_W-1:ROW_BITS];

    assign cas_n    = {ucas_n, lcas_n};
    assign ras_fall = st_q.ras & ~ras_n;
    assign ras_rise = ~st_q.ras & ras_n;
    assign we_fall  = st_q.we & ~we_n;
    assign cas_fall = st_q.cas & ~cas_n;
    assign cas_rise = ~st_q.cas & cas_n;
    // a column strobe already low at row-strobe fall selects the internal counter
    assign row_sel  = (&cas_n) ? addr[ROW_BITS-1:0] : st_q.ctr;
    assign wlanes   = st_q.act & ~st_q.early & ~cas_n;

    dram_resp_ages #(
        .ROW_BITS    (ROW_BITS),
        .REFRESH_WIN (REFRESH_WIN)
    ) u_ages (
        .clk       (clk),
        .rst       (rst),
        .ref_en    (ras_fall),
        .sel_row   (row_sel),
        .sel_stale (row_stale)
    );

    dram_resp_array #(
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS),
        .LANE_W   (LANE_W),
        .LANES    (LANES)
    ) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr ({st_q.row, wr_col}),
        .wr_data (dq_in),
        .rd_addr ({st_q.row, addr[COL_BITS-1:0]}),
        .rd_data (rd_data)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ras = ras_n;
        st_d.cas = cas_n;
        st_d.we  = we_n;
        wr_en    = '0;
        wr_col   = st_q.col;

        // row strobe fall: row-only refresh / access open, or counter refresh
        if (ras_fall) begin
            st_d.row   = row_sel;
            st_d.stale = row_stale;
            if (&cas_n) begin
                st_d.cls = CYC_ROW_REF;
            end else begin
                st_d.cls = CYC_CBR;
                st_d.ctr = st_q.ctr + 1'b1;
            end
        end
        if (ras_rise) begin
            st_d.act   = '0;
            st_d.early = '0;
        end

        // late write strobe: delayed write or read-modify-write
        if (we_fall && !ras_n && (|wlanes)) begin
            wr_en    = wlanes;
            st_d.cls = (|(st_q.shown & wlanes)) ? CYC_RMW : CYC_DELAYED_WR;
        end

        for (int l = 0; l < LANES; l++) begin
            if (cas_rise[l]) begin
                st_d.act[l]   = 1'b0;
                st_d.early[l] = 1'b0;
                st_d.valid[l] = 1'b0;
                st_d.shown[l] = 1'b0;
            end else if (cas_fall[l]) begin
                if (!ras_n && !ras_fall) begin
                    st_d.act[l] = 1'b1;
                    st_d.col    = addr[COL_BITS-1:0];
                    if (q_stale_hit()) st_d.err = 1'b1;
                    if (!we_n) begin
                        st_d.early[l] = 1'b1;
                        st_d.valid[l] = 1'b0;
                        wr_en[l]      = 1'b1;
                        wr_col        = addr[COL_BITS-1:0];
                        st_d.cls      = CYC_EARLY_WR;
                    end else begin
                        st_d.early[l] = 1'b0;
                        st_d.valid[l] = 1'b1;
                        st_d.dout[l*LANE_W +: LANE_W] = rd_data[l*LANE_W +: LANE_W];
                        st_d.cls      = CYC_READ;
                    end
                end else begin
                    st_d.act[l]   = 1'b0;
                    st_d.early[l] = 1'b0;
                    st_d.valid[l] = 1'b0;
                end
            end
        end

        for (int l = 0; l < LANES; l++) begin
            st_d.drv[l]   = ~cas_n[l] & ~oe_n & st_d.valid[l] & ~st_d.early[l];
            st_d.shown[l] = st_d.shown[l] | st_d.drv[l];
        end

        if (ras_n && (&cas_n)) begin
            st_d.cls = CYC_STANDBY;
        end
    end

    function automatic logic q_stale_hit();
        return st_q.stale;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.ras   <= 1'b1;
            st_q.cas   <= '1;
            st_q.we    <= 1'b1;
            st_q.cls   <= CYC_STANDBY;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_out
        assign dq_out[g*LANE_W +: LANE_W] = st_q.drv[g] ? st_q.dout[g*LANE_W +: LANE_W] : '0;
    end
    assign dq_drv      = st_q.drv;
    assign cyc_class   = st_q.cls;
    assign refresh_err = st_q.err;

    // R1: all strobes high gives standby on the following cycle
    a_r1_standby: assert property (@(posedge clk) disable iff (rst)
        (ras_n && lcas_n && ucas_n) |=> (cyc_class == CYC_STANDBY));

    // R3: lane 0 never drives right after an early-write strobe
    a_r3_early_hiz: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && !$fell(ras_n) && $fell(lcas_n) && !we_n) |=> !dq_drv[0]);

    // R4: output enable high means no lane drives on the next cycle
    a_r4_oe_gate: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> (dq_drv == 2'b00));

    // R8: a column-before-row refresh steps the refresh counter by one
    a_r8_ctr_step: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !(lcas_n && ucas_n)) |=> (st_q.ctr == ROW_BITS'($past(st_q.ctr) + 1'b1)));

    // R11: the stale-access flag holds once set
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
        refresh_err |=> refresh_err);

endmodule

// File: tb/dram_resp_tb.sv
`timescale 1ns/1ps
module dram_resp_tb;
    localparam int ROWB = 4;
    localparam int COLB = 3;
    localparam int NROW = 1 << ROWB;
    localparam int NCOL = 1 << COLB;
    localparam int WIN  = 2000;

    logic        clk = 1'b0;
    logic        rst;
    logic        ras_n, lcas_n, ucas_n, we_n, oe_n;
    logic [11:0] addr;
    logic [15:0] dq_in;
    logic [15:0] dq_out;
    logic [1:0]  dq_drv;
    logic [2:0]  cyc_class;
    logic        refresh_err;

    always #10 clk = ~clk;

    dram_resp #(
        .ADDR_W (12), .ROW_BITS (ROWB), .COL_BITS (COLB),
        .LANE_W (8), .REFRESH_WIN (WIN)
    ) u_dut (
        .clk (clk), .rst (rst), .ras_n (ras_n), .lcas_n (lcas_n), .ucas_n (ucas_n),
        .we_n (we_n), .oe_n (oe_n), .addr (addr), .dq_in (dq_in),
        .dq_out (dq_out), .dq_drv (dq_drv), .cyc_class (cyc_class),
        .refresh_err (refresh_err)
    );

    int          n_checks = 0;
    int          n_fail   = 0;
    bit          finished = 0;
    logic [15:0] mem_m [NROW][NCOL];
    int          ctr_m = 0;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] mk_row(input int r);
        return {8'($urandom), 4'(r)};
    endfunction

    function automatic logic [11:0] mk_col(input int c);
        return {9'($urandom), 3'(c)};
    endfunction

    function automatic logic [15:0] lane_mask(input logic [1:0] ln);
        return {{8{ln[1]}}, {8{ln[0]}}};
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                          input logic [1:0] ln);
        return (old & ~lane_mask(ln)) | (nw & lane_mask(ln));
    endfunction

    task automatic set_cas(input logic [1:0] ln);
        lcas_n = ~ln[0];
        ucas_n = ~ln[1];
    endtask

    task automatic open_row(input int r);
        addr = mk_row(r); ras_n = 1'b0; tick();
        chk(cyc_class == 3'd5, "R7", "class after row open", cyc_class, 5);
    endtask

    task automatic close_row();
        ras_n = 1'b1; tick();
        chk(cyc_class == 3'd0, "R1", "standby class", cyc_class, 0);
    endtask

    task automatic early_write(input int r, input int c, input logic [1:0] ln, input logic [15:0] d);
        open_row(r);
        addr = mk_col(c); we_n = 1'b0; dq_in = d; set_cas(ln); tick();
        chk(dq_drv == 2'b00, "R3", "early write drive", dq_drv, 0);
        chk(cyc_class == 3'd2, "R3", "early write class", cyc_class, 2);
        mem_m[r][c] = merge(mem_m[r][c], d, ln);
        set_cas(2'b00); we_n = 1'b1; tick();
        close_row();
    endtask

    task automatic read_word(input int r, input int c, input logic [1:0] ln);
        open_row(r);
        addr = mk_col(c); oe_n = 1'b0; set_cas(ln); tick();
        chk(dq_drv == ln, "R4", "read drive lanes", dq_drv, ln);
        chk(dq_out == (mem_m[r][c] & lane_mask(ln)), "R2", "read data",
            dq_out, mem_m[r][c] & lane_mask(ln));
        chk(cyc_class == 3'd1, "R2", "read class", cyc_class, 1);
        set_cas(2'b00); oe_n = 1'b1; tick();
        chk(dq_drv == 2'b00, "R4", "drive after strobe rise", dq_drv, 0);
        close_row();
    endtask

    task automatic delayed_write(input int r, input int c, input logic [1:0] ln, input logic [15:0] d);
        open_row(r);
        addr = mk_col(c); oe_n = 1'b1; set_cas(ln); tick();
        chk(dq_drv == 2'b00, "R4", "no drive with oe high", dq_drv, 0);
        we_n = 1'b0; dq_in = d; tick();
        chk(cyc_class == 3'd3, "R5", "delayed write class", cyc_class, 3);
        mem_m[r][c] = merge(mem_m[r][c], d, ln);
        set_cas(2'b00); we_n = 1'b1; tick();
        close_row();
    endtask

    task automatic rmw(input int r, input int c, input logic [1:0] ln, input logic [15:0] d);
        open_row(r);
        addr = mk_col(c); oe_n = 1'b0; set_cas(ln); tick();
        chk(dq_out == (mem_m[r][c] & lane_mask(ln)), "R6", "rmw read part",
            dq_out, mem_m[r][c] & lane_mask(ln));
        oe_n = 1'b1; tick();
        we_n = 1'b0; dq_in = d; tick();
        chk(cyc_class == 3'd4, "R6", "rmw class", cyc_class, 4);
        mem_m[r][c] = merge(mem_m[r][c], d, ln);
        set_cas(2'b00); we_n = 1'b1; tick();
        close_row();
    endtask

    task automatic row_refresh(input int r);
        open_row(r);
        chk(dq_drv == 2'b00, "R7", "row refresh drive", dq_drv, 0);
        close_row();
    endtask

    task automatic cbr_refresh();
        set_cas(2'b11); tick();
        ras_n = 1'b0; tick();
        chk(cyc_class == 3'd6, "R8", "cbr class", cyc_class, 6);
        chk(dq_drv == 2'b00, "R8", "cbr drive", dq_drv, 0);
        ctr_m = (ctr_m + 1) % NROW;
        set_cas(2'b00); tick();
        close_row();
    endtask

    task automatic counter_test(input int c, input logic [1:0] ln);
        int rr;
        set_cas(2'b11); tick();
        ras_n = 1'b0; tick();
        chk(cyc_class == 3'd6, "R8", "counter test refresh class", cyc_class, 6);
        rr = ctr_m;
        ctr_m = (ctr_m + 1) % NROW;
        set_cas(2'b00); tick();
        addr = mk_col(c); oe_n = 1'b0; set_cas(ln); tick();
        chk(dq_out == (mem_m[rr][c] & lane_mask(ln)), "R10", "counter test data",
            dq_out, mem_m[rr][c] & lane_mask(ln));
        set_cas(2'b00); oe_n = 1'b1; tick();
        close_row();
    endtask

    task automatic hidden_refresh(input int r, input int c);
        open_row(r);
        addr = mk_col(c); oe_n = 1'b0; set_cas(2'b11); tick();
        chk(dq_out == mem_m[r][c], "R2", "hidden read data", dq_out, mem_m[r][c]);
        ras_n = 1'b1; tick();
        chk(dq_drv == 2'b11 && dq_out == mem_m[r][c], "R9", "data held, row strobe high",
            dq_out, mem_m[r][c]);
        ras_n = 1'b0; tick();
        chk(cyc_class == 3'd6, "R8", "hidden refresh class", cyc_class, 6);
        chk(dq_drv == 2'b11 && dq_out == mem_m[r][c], "R9", "data held through refresh",
            dq_out, mem_m[r][c]);
        ctr_m = (ctr_m + 1) % NROW;
        set_cas(2'b00); oe_n = 1'b1; tick();
        chk(dq_drv == 2'b00, "R4", "drive released", dq_drv, 0);
        close_row();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int seed_set;
        seed_set = $urandom(32'h1d2c3b4a);
        rst = 1'b1; ras_n = 1'b1; lcas_n = 1'b1; ucas_n = 1'b1;
        we_n = 1'b1; oe_n = 1'b1; addr = '0; dq_in = '0;
        repeat (3) tick();
        rst = 1'b0; tick();
        chk(dq_drv == 2'b00, "R1", "reset drive", dq_drv, 0);
        chk(cyc_class == 3'd0, "R1", "reset class", cyc_class, 0);
        chk(refresh_err == 1'b0, "R1", "reset error flag", refresh_err, 0);

        // fill the array with known words in fast page early writes
        for (int r = 0; r < NROW; r++) begin
            addr = mk_row(r); ras_n = 1'b0; tick();
            for (int c = 0; c < NCOL; c++) begin
                logic [15:0] d;
                d = 16'($urandom);
                addr = mk_col(c); we_n = 1'b0; dq_in = d; set_cas(2'b11); tick();
                mem_m[r][c] = d;
                set_cas(2'b00); we_n = 1'b1; tick();
            end
            ras_n = 1'b1; tick();
        end

        // directed corners
        read_word(3, 5, 2'b11);
        early_write(3, 5, 2'b01, 16'hA55A);
        read_word(3, 5, 2'b11);
        delayed_write(7, 2, 2'b10, 16'h3CC3);
        read_word(7, 2, 2'b11);
        rmw(9, 6, 2'b11, 16'hBEEF);
        read_word(9, 6, 2'b11);
        row_refresh(4);
        cbr_refresh();
        counter_test(1, 2'b11);
        hidden_refresh(2, 7);
        counter_test(4, 2'b10);

        // constrained random mix
        for (int i = 0; i < 150; i++) begin
            int          r, c, op;
            logic [1:0]  ln;
            logic [15:0] d;
            r  = $urandom_range(0, NROW - 1);
            c  = $urandom_range(0, NCOL - 1);
            op = $urandom_range(0, 7);
            ln = 2'($urandom_range(1, 3));
            d  = 16'($urandom);
            case (op)
                0, 1: read_word(r, c, ln);
                2:    early_write(r, c, ln, d);
                3:    delayed_write(r, c, ln, d);
                4:    rmw(r, c, ln, d);
                5:    row_refresh(r);
                6:    counter_test(c, ln);
                default: hidden_refresh(r, c);
            endcase
        end
        chk(refresh_err == 1'b0, "R11", "no stale access yet", refresh_err, 0);

        // staleness: idle past the window, refresh one row, then access two rows
        repeat (WIN + 100) tick();
        chk(refresh_err == 1'b0, "R11", "idle raises nothing", refresh_err, 0);
        row_refresh(5);
        read_word(5, 0, 2'b11);
        chk(refresh_err == 1'b0, "R11", "fresh row access", refresh_err, 0);
        read_word(6, 0, 2'b11);
        chk(refresh_err == 1'b1, "R11", "stale row access", refresh_err, 1);
        repeat (10) tick();
        chk(refresh_err == 1'b1, "R11", "flag sticky", refresh_err, 1);

        summary();
    end

endmodule